// File: doc/BRIEF.md
# Differential Clock Output Power and Mode Controller

This block is the control logic for a differential clock output stage. It watches an active-low power-down input, an active-low clock-stop input, a three-bit test/bypass mode select and a two-bit multiplier select. From them it derives a three-state power machine, the source and drive state of the two output legs, and the PLL feedback and prescaler divider values. All timing runs on the reference clock. Every control input passes through a two-flop synchronizer before it is decoded.

The mode select is captured only while the block is powered down. The multiplier select may change at any time. A change outside power-down starts a shorter re-settle window. Parameterized down-counters time the PLL settle, the output restart window after a clock stop, and the glitch window at the start of that restart. A sticky error flag reports a clock stop held too long, or a run phase cut too short before the next stop. The error flag clears in power-down.

Top module: `clkout_ctrl`

## Requirements
- R1: The power state `state_o` is 2'b00 (power-down) while the power input is low, whatever the stop input is. It is 2'b01 (clock stopped) when power is high and stop is low, and 2'b10 (running) when both are high. An input change shows on `state_o` after the third rising clock edge.
- R2: In power-down, `out_low_o` is 1 and `out_en_o`, `out_hiz_o`, `dc_hold_o` are 0. In the stopped state, `out_hiz_o` and `dc_hold_o` are 1 and `out_en_o`, `out_low_o` are 0.
- R3: While running, the captured mode {S0,S1,S2} = `mode_i[2:0]` drives the legs. 000 drives them from the aligned clock (`src_sel_o`=0). 100 drives them from the PLL bypass (1). 110 drives them from the reference (2). In these three modes `out_en_o` is 1. With S0=0 and S1=1, `out_hiz_o` is 1. The codes 001, 101 and 111 hold the legs low (`out_low_o`=1). In every non-driving mode `src_sel_o` is 3.
- R4: The multiplier code {M0,M1} = `mul_i[1:0]` sets the feedback divider `div_fb_o` and the prescaler `div_pre_o`: 00 gives 9 and 2, 01 gives 6 and 1, 10 gives 16 and 3, 11 gives 8 and 1.
- R5: The mode select is sampled only in power-down. A change while running leaves `src_sel_o` and the leg drive unchanged.
- R6: `pll_ok_o` is 0 in power-down. It rises exactly PLL_CYC cycles after `state_o` leaves power-down.
- R7: A multiplier change outside power-down clears `pll_ok_o` on the same edge on which the divider outputs change. The flag returns MULT_CYC cycles later.
- R8: On entry to running, `out_unspec_o` is 1 for UNSPEC_CYC cycles. `out_ok_o` rises RESTART_CYC cycles after entry, but never while `pll_ok_o` is 0.
- R9: A stopped phase lasting more than STOP_MAX cycles sets `err_o`. A stop of exactly STOP_MAX cycles does not.
- R10: Entering the stopped state from a running phase shorter than RUN_MIN cycles sets `err_o`.
- R11: `err_o` is sticky. It clears on the edge after `state_o` shows power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_n_i | input | 1 | Active-low power-down request |
| stop_n_i | input | 1 | Active-low clock-stop request |
| mode_i | input | 3 | Mode select {S0,S1,S2} |
| mul_i | input | 2 | Multiplier select {M0,M1} |
| state_o | output | 2 | Power state code |
| src_sel_o | output | 2 | Output source select |
| out_en_o | output | 1 | Legs drive a clock |
| out_hiz_o | output | 1 | Legs in high impedance |
| out_low_o | output | 1 | Legs held low |
| dc_hold_o | output | 1 | Clock-stop DC level requested |
| div_fb_o | output | 5 | PLL feedback divider |
| div_pre_o | output | 2 | PLL prescaler divider |
| pll_ok_o | output | 1 | PLL settle window elapsed |
| out_ok_o | output | 1 | Output fully settled |
| out_unspec_o | output | 1 | Output in glitch window |
| err_o | output | 1 | Dwell rule violated (sticky) |

## Verification
The assertions assume that every control input stays steady for at least three reference cycles. Without that, the synchronizers cannot settle and the state code could step through an intermediate value. The stimulus meets this assumption by changing inputs only on falling edges and then waiting at least three cycles before the next change or sample. The mode-freeze check also assumes that the mode code changes only in power-down, or that a change while running is expected to be ignored. The bench drives mode changes outside power-down only to confirm that they are ignored.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

    localparam int DIV_A_W = 5;
    localparam int DIV_B_W = 2;

    typedef enum logic [1:0] {
        ST_PD   = 2'b00,
        ST_STOP = 2'b01,
        ST_RUN  = 2'b10
    } pstate_e;

    typedef enum logic [1:0] {
        SRC_ALIGNED = 2'd0,
        SRC_BYPASS  = 2'd1,
        SRC_REF     = 2'd2,
        SRC_NONE    = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        K_DRIVE = 2'd0,
        K_HIZ   = 2'd1,
        K_LOW   = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e kind;
        src_e  src;
    } mode_dec_t;

    // m = {S0,S1,S2}
    function automatic mode_dec_t decode_mode(input logic [2:0] m);
        mode_dec_t r;
        r.kind = K_LOW;
        r.src  = SRC_NONE;
        if (!m[2] && m[1]) begin
            r.kind = K_HIZ;
        end else begin
            case (m)
                3'b000: begin r.kind = K_DRIVE; r.src = SRC_ALIGNED; end
                3'b100: begin r.kind = K_DRIVE; r.src = SRC_BYPASS;  end
                3'b110: begin r.kind = K_DRIVE; r.src = SRC_REF;     end
                default: begin r.kind = K_LOW; r.src = SRC_NONE;     end
            endcase
        end
        return r;
    endfunction

    // c = {M0,M1}
    function automatic logic [DIV_A_W-1:0] fb_div(input logic [1:0] c);
        case (c)
            2'b00:   return DIV_A_W'(9);
            2'b01:   return DIV_A_W'(6);
            2'b10:   return DIV_A_W'(16);
            default: return DIV_A_W'(8);
        endcase
    endfunction

    function automatic logic [DIV_B_W-1:0] pre_div(input logic [1:0] c);
        case (c)
            2'b00:   return DIV_B_W'(2);
            2'b10:   return DIV_B_W'(3);
            default: return DIV_B_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/clkout_sync.sv
module clkout_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1_q, s2_q;
        logic s1_d, s2_d;

        always_comb begin
            s1_d = d_i[i];
            s2_d = s1_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= s1_d;
                s2_q <= s2_d;
            end
        end

        assign q_o[i] = s2_q;
    end
endmodule

// File: rtl/clkout_settle.sv
module clkout_settle import clkout_pkg::*; #(
    parameter int PLL_CYC     = 40,
    parameter int MULT_CYC    = 24,
    parameter int RESTART_CYC = 20,
    parameter int UNSPEC_CYC  = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  pstate_e state_i,
    input  logic    mult_chg_i,
    output logic    pll_ok_o,
    output logic    out_ok_o,
    output logic    out_unspec_o
);
    localparam int MAXC = (PLL_CYC > MULT_CYC ? PLL_CYC : MULT_CYC) > RESTART_CYC ?
                          (PLL_CYC > MULT_CYC ? PLL_CYC : MULT_CYC) : RESTART_CYC;
    localparam int CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] UNSPEC_EDGE = CW'(RESTART_CYC - UNSPEC_CYC);

    typedef struct packed {
        logic [CW-1:0] pll_cnt;
        logic [CW-1:0] out_cnt;
    } settle_t;

    settle_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (state_i == ST_PD) begin
            s_d.pll_cnt = CW'(PLL_CYC);
        end else if (mult_chg_i) begin
            s_d.pll_cnt = CW'(MULT_CYC);
        end else if (s_q.pll_cnt != '0) begin
            s_d.pll_cnt = s_q.pll_cnt - 1'b1;
        end

        if (state_i != ST_RUN) begin
            s_d.out_cnt = CW'(RESTART_CYC);
        end else if (s_q.out_cnt != '0) begin
            s_d.out_cnt = s_q.out_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pll_cnt <= CW'(PLL_CYC);
            s_q.out_cnt <= CW'(RESTART_CYC);
        end else begin
            s_q <= s_d;
        end
    end

    assign pll_ok_o     = (state_i != ST_PD) && (s_q.pll_cnt == '0);
    assign out_ok_o     = (state_i == ST_RUN) && (s_q.out_cnt == '0) && pll_ok_o;
    assign out_unspec_o = (state_i == ST_RUN) && (s_q.out_cnt > UNSPEC_EDGE);
endmodule

// File: rtl/clkout_dwell.sv
module clkout_dwell import clkout_pkg::*; #(
    parameter int STOP_MAX = 60,
    parameter int RUN_MIN  = 10
) (
    input  logic    clk,
    input  logic    rst_n,
    input  pstate_e state_q_i,
    input  pstate_e state_d_i,
    output logic    err_o
);
    localparam int RW = $clog2(RUN_MIN + 1);
    localparam int SW = $clog2(STOP_MAX + 1);
    localparam logic [RW-1:0] RUN_SAT  = RW'(RUN_MIN);
    localparam logic [SW-1:0] STOP_SAT = SW'(STOP_MAX - 1);

    typedef struct packed {
        logic [RW-1:0] run_cnt;
        logic [SW-1:0] stop_cnt;
        logic          err;
    } dwell_t;

    dwell_t w_d, w_q;
    logic   run_short;
    logic   stop_long;

    always_comb begin
        w_d       = w_q;
        run_short = (int'(w_q.run_cnt) + 1) < RUN_MIN;
        stop_long = w_q.stop_cnt >= STOP_SAT;

        if (state_q_i == ST_RUN) begin
            if (w_q.run_cnt != RUN_SAT) w_d.run_cnt = w_q.run_cnt + 1'b1;
        end else begin
            w_d.run_cnt = '0;
        end

        if (state_q_i == ST_STOP) begin
            if (w_q.stop_cnt != STOP_SAT) w_d.stop_cnt = w_q.stop_cnt + 1'b1;
        end else begin
            w_d.stop_cnt = '0;
        end

        if (state_q_i == ST_PD) begin
            w_d.err = 1'b0;
        end else if (state_q_i == ST_RUN && state_d_i == ST_STOP && run_short) begin
            w_d.err = 1'b1;
        end else if (state_q_i == ST_STOP && state_d_i == ST_STOP && stop_long) begin
            w_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign err_o = w_q.err;
endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl import clkout_pkg::*; #(
    parameter int PLL_CYC     = 40,
    parameter int MULT_CYC    = 24,
    parameter int RESTART_CYC = 20,
    parameter int UNSPEC_CYC  = 2,
    parameter int STOP_MAX    = 60,
    parameter int RUN_MIN     = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_n_i,
    input  logic               stop_n_i,
    input  logic [2:0]         mode_i,
    input  logic [1:0]         mul_i,
    output logic [1:0]         state_o,
    output logic [1:0]         src_sel_o,
    output logic               out_en_o,
    output logic               out_hiz_o,
    output logic               out_low_o,
    output logic               dc_hold_o,
    output logic [DIV_A_W-1:0] div_fb_o,
    output logic [DIV_B_W-1:0] div_pre_o,
    output logic               pll_ok_o,
    output logic               out_ok_o,
    output logic               out_unspec_o,
    output logic               err_o
);
    localparam int NSYNC = 2 + 3 + 2;

    typedef struct packed {
        pstate_e    st;
        logic [2:0] mode;
        logic [1:0] mul;
    } ctl_t;

    logic [NSYNC-1:0] raw, syn;
    logic             pwr_s, stop_s;
    logic [2:0]       mode_s;
    logic [1:0]       mul_s;
    ctl_t             c_d, c_q;
    logic             mult_chg;
    mode_dec_t        md;

    assign raw = {pwr_n_i, stop_n_i, mode_i, mul_i};

    clkout_sync #(.W(NSYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (syn)
    );

    assign {pwr_s, stop_s, mode_s, mul_s} = syn;

    always_comb begin
        c_d = c_q;
        if (!pwr_s)      c_d.st = ST_PD;
        else if (!stop_s) c_d.st = ST_STOP;
        else             c_d.st = ST_RUN;
        if (!pwr_s) c_d.mode = mode_s;
        c_d.mul  = mul_s;
        mult_chg = (mul_s != c_q.mul);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st   <= ST_PD;
            c_q.mode <= '0;
            c_q.mul  <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    clkout_settle #(
        .PLL_CYC     (PLL_CYC),
        .MULT_CYC    (MULT_CYC),
        .RESTART_CYC (RESTART_CYC),
        .UNSPEC_CYC  (UNSPEC_CYC)
    ) u_settle (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_i      (c_q.st),
        .mult_chg_i   (mult_chg),
        .pll_ok_o     (pll_ok_o),
        .out_ok_o     (out_ok_o),
        .out_unspec_o (out_unspec_o)
    );

    clkout_dwell #(
        .STOP_MAX (STOP_MAX),
        .RUN_MIN  (RUN_MIN)
    ) u_dwell (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_q_i (c_q.st),
        .state_d_i (c_d.st),
        .err_o     (err_o)
    );

    always_comb begin
        md        = decode_mode(c_q.mode);
        src_sel_o = md.src;
        out_en_o  = 1'b0;
        out_hiz_o = 1'b0;
        out_low_o = 1'b0;
        dc_hold_o = 1'b0;
        case (c_q.st)
            ST_PD:   out_low_o = 1'b1;
            ST_STOP: begin
                out_hiz_o = 1'b1;
                dc_hold_o = 1'b1;
            end
            default: begin
                out_en_o  = (md.kind == K_DRIVE);
                out_hiz_o = (md.kind == K_HIZ);
                out_low_o = (md.kind == K_LOW);
            end
        endcase
    end

    assign state_o   = c_q.st;
    assign div_fb_o  = fb_div(c_q.mul);
    assign div_pre_o = pre_div(c_q.mul);
endmodule

// File: rtl/clkout_ctrl_chk.sv
module clkout_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] state_o,
    input logic [1:0] src_sel_o,
    input logic       out_en_o,
    input logic       out_hiz_o,
    input logic       out_low_o,
    input logic       dc_hold_o,
    input logic [4:0] div_fb_o,
    input logic [1:0] div_pre_o,
    input logic       pll_ok_o,
    input logic       out_ok_o,
    input logic       err_o
);
    AST_PD_LEGS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'b00 |-> out_low_o && !out_en_o && !out_hiz_o && !dc_hold_o); // R2
    AST_STOP_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'b01 |-> out_hiz_o && dc_hold_o && !out_en_o && !out_low_o); // R2
    AST_ONE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_en_o, out_hiz_o, out_low_o})); // R3
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != 2'b11); // R1
    AST_PRE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        div_pre_o != 2'b00 && div_fb_o != 5'd0); // R4
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != 2'b00 && $past(state_o) != 2'b00 |-> $stable(src_sel_o)); // R5
    AST_PLL_DOWN_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'b00 |-> !pll_ok_o); // R6
    AST_MULT_RESETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_fb_o) |-> !pll_ok_o); // R7
    AST_OK_NEEDS_PLL: assert property (@(posedge clk) disable iff (!rst_n)
        out_ok_o |-> pll_ok_o && state_o == 2'b10); // R8
    AST_ERR_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> state_o == 2'b01); // R9 R10
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'b00 |=> !err_o); // R11
endmodule

bind clkout_ctrl clkout_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_o   (state_o),
    .src_sel_o (src_sel_o),
    .out_en_o  (out_en_o),
    .out_hiz_o (out_hiz_o),
    .out_low_o (out_low_o),
    .dc_hold_o (dc_hold_o),
    .div_fb_o  (div_fb_o),
    .div_pre_o (div_pre_o),
    .pll_ok_o  (pll_ok_o),
    .out_ok_o  (out_ok_o),
    .err_o     (err_o)
);

// File: tb/clkout_ctrl_bench.sv
`timescale 1ns/1ps
module clkout_ctrl_bench;
    localparam int PLL_CYC     = 40;
    localparam int MULT_CYC    = 24;
    localparam int RESTART_CYC = 20;
    localparam int UNSPEC_CYC  = 2;
    localparam int STOP_MAX    = 60;
    localparam int RUN_MIN     = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pwr_n, stop_n;
    logic [2:0] mode;
    logic [1:0] mul;
    logic [1:0] state, src_sel;
    logic       out_en, out_hiz, out_low, dc_hold;
    logic [4:0] div_fb;
    logic [1:0] div_pre;
    logic       pll_ok, out_ok, out_unspec, err;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    clkout_ctrl #(
        .PLL_CYC (PLL_CYC), .MULT_CYC (MULT_CYC), .RESTART_CYC (RESTART_CYC),
        .UNSPEC_CYC (UNSPEC_CYC), .STOP_MAX (STOP_MAX), .RUN_MIN (RUN_MIN)
    ) u_clkout_ctrl (
        .clk (clk), .rst_n (rst_n), .pwr_n_i (pwr_n), .stop_n_i (stop_n),
        .mode_i (mode), .mul_i (mul), .state_o (state), .src_sel_o (src_sel),
        .out_en_o (out_en), .out_hiz_o (out_hiz), .out_low_o (out_low),
        .dc_hold_o (dc_hold), .div_fb_o (div_fb), .div_pre_o (div_pre),
        .pll_ok_o (pll_ok), .out_ok_o (out_ok), .out_unspec_o (out_unspec),
        .err_o (err)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset;
        chk("R1", "reset state", state, 0);
        chk("R2", "reset legs low", out_low, 1);
        chk("R6", "reset pll_ok", pll_ok, 0);
        chk("R11", "reset err", err, 0);
    endtask

    task automatic t_powerup;
        mode = 3'b000; mul = 2'b00; stop_n = 1'b1;
        step(4);
        pwr_n = 1'b1;
        step(2);
        chk("R1", "state before third edge", state, 0);
        step(1);
        chk("R1", "state running", state, 2);
        chk("R3", "aligned drive en", out_en, 1);
        chk("R3", "aligned src", src_sel, 0);
        chk("R4", "fb div code 00", div_fb, 9);
        chk("R4", "pre div code 00", div_pre, 2);
        step(PLL_CYC - 1);
        chk("R6", "pll_ok one cycle early", pll_ok, 0);
        chk("R8", "out_ok before pll", out_ok, 0);
        step(1);
        chk("R6", "pll_ok at settle", pll_ok, 1);
        chk("R8", "out_ok after pll", out_ok, 1);
    endtask

    task automatic t_mult;
        int ea [4] = '{9, 6, 16, 8};
        int eb [4] = '{2, 1, 3, 1};
        for (int c = 1; c < 4; c++) begin
            mul = 2'(c);
            step(2);
            chk("R7", "pll_ok before change lands", pll_ok, 1);
            step(1);
            chk("R4", "fb div", div_fb, ea[c]);
            chk("R4", "pre div", div_pre, eb[c]);
            chk("R7", "pll_ok cleared", pll_ok, 0);
            step(MULT_CYC - 1);
            chk("R7", "pll_ok one cycle early", pll_ok, 0);
            step(1);
            chk("R7", "pll_ok back", pll_ok, 1);
        end
    endtask

    task automatic t_mode_ignored;
        mode = 3'b110;
        step(6);
        chk("R5", "src unchanged in run", src_sel, 0);
        chk("R5", "drive unchanged in run", out_en, 1);
        mode = 3'b000;
        step(3);
    endtask

    task automatic t_restart;
        step(RUN_MIN);
        stop_n = 1'b0;
        step(3);
        chk("R1", "state stopped", state, 1);
        chk("R2", "stop hiz", out_hiz, 1);
        chk("R2", "stop dc hold", dc_hold, 1);
        chk("R2", "stop no drive", out_en, 0);
        step(10);
        stop_n = 1'b1;
        step(3);
        chk("R8", "unspec first cycle", out_unspec, 1);
        chk("R8", "out_ok at entry", out_ok, 0);
        step(UNSPEC_CYC - 1);
        chk("R8", "unspec last cycle", out_unspec, 1);
        step(1);
        chk("R8", "unspec over", out_unspec, 0);
        step(RESTART_CYC - UNSPEC_CYC - 1);
        chk("R8", "out_ok one cycle early", out_ok, 0);
        step(1);
        chk("R8", "out_ok settled", out_ok, 1);
        chk("R9", "short stop no err", err, 0);
    endtask

    task automatic t_run_min;
        stop_n = 1'b0;
        step(3);
        stop_n = 1'b1;
        step(3);
        chk("R10", "no err before short run ends", err, 0);
        stop_n = 1'b0;
        step(3);
        chk("R10", "short run err", err, 1);
        step(5);
        chk("R11", "err sticky", err, 1);
        pwr_n = 1'b0;
        step(3);
        chk("R1", "pd with stop low", state, 0);
        chk("R2", "pd legs low", out_low, 1);
        chk("R11", "err still set on pd entry", err, 1);
        step(1);
        chk("R11", "err cleared in pd", err, 0);
        stop_n = 1'b1;
        step(3);
    endtask

    task automatic t_stop_max;
        pwr_n = 1'b1;
        step(3 + RUN_MIN + 5);
        stop_n = 1'b0;
        step(3 + STOP_MAX - 1);
        chk("R9", "stop at limit no err", err, 0);
        step(1);
        chk("R9", "stop over limit err", err, 1);
        stop_n = 1'b1;
        pwr_n = 1'b0;
        step(5);
    endtask

    task automatic t_mode_table;
        for (int m = 0; m < 8; m++) begin
            int e_en, e_hiz, e_low, e_src;
            e_en = 0; e_hiz = 0; e_low = 0; e_src = 3;
            if (m == 3'b000) begin e_en = 1; e_src = 0; end
            else if (m == 3'b100) begin e_en = 1; e_src = 1; end
            else if (m == 3'b110) begin e_en = 1; e_src = 2; end
            else if (m == 3'b010 || m == 3'b011) e_hiz = 1;
            else e_low = 1;
            mode = 3'(m);
            step(3);
            pwr_n = 1'b1;
            step(3);
            chk("R3", $sformatf("en mode %0d", m), out_en, e_en);
            chk("R3", $sformatf("hiz mode %0d", m), out_hiz, e_hiz);
            chk("R3", $sformatf("low mode %0d", m), out_low, e_low);
            chk("R3", $sformatf("src mode %0d", m), src_sel, e_src);
            pwr_n = 1'b0;
            step(3);
        end
    endtask

    initial begin
        rst_n = 1'b0; pwr_n = 1'b0; stop_n = 1'b0; mode = '0; mul = '0;
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_powerup();
        t_mult();
        t_mode_ignored();
        t_restart();
        t_run_min();
        t_stop_max();
        t_mode_table();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule